// File: doc/BRIEF.md
# Supervisor Reset Pulse Sequencer

This block produces the active-low reset that holds a processor in a known state. It collects four kinds of request. Two are level flags from supply monitors: the main rail is low, or the auxiliary monitored input is low. The third is a raw active-low manual-reset line from a push button or external logic. The fourth is a single-cycle fault strobe from a watchdog. While any request is present the output stays asserted. Once the last request goes away, the output is held for a programmable number of clock cycles and then released.

The three asynchronous inputs each pass through a two-flop synchronizer. The manual line then goes through a width qualifier: a low pulse shorter than the qualifying length is treated as noise and has no effect. The watchdog strobe is already synchronous to the clock, so it enters the request merge directly. A lone strobe gives one reset pulse exactly one timeout long.

There is also a `reset_active` flag. It is high whenever reset is asserted, so that watchdog timers can hold themselves cleared during reset. After the block's own reset is released, the output stays asserted for one full timeout, which gives a power-on reset pulse.

Top module: `supervisor_rst_seq`

## Requirements
In R1 to R9, "edge P" means the first rising clock edge that sees the new input value. Edge numbers count forward from there.
- R1: Main-supply flag high (1 = below threshold) applied before edge P drives `rst_out_n` low at edge P+2. The output stays low while the flag stays high.
- R2: Auxiliary flag high applied before edge P drives `rst_out_n` low at edge P+2, with the same holding behaviour. Either flag on its own is sufficient.
- R3: A supply flag cleared before edge Q leaves `rst_out_n` low until edge Q+1+TIMEOUT, where it goes high.
- R4: A manual-reset low pulse lasting fewer than MR_QUAL clock cycles has no effect. `rst_out_n` stays high.
- R5: A manual-reset low lasting at least MR_QUAL cycles, starting before edge P, drives `rst_out_n` low at edge P+MR_QUAL+2. Any high sample on the line restarts the width count.
- R6: Manual reset released before edge R leaves `rst_out_n` low until edge R+2+TIMEOUT.
- R7: A one-cycle watchdog strobe present at edge P gives a low pulse from edge P to edge P+TIMEOUT, exactly TIMEOUT cycles. A further strobe at edge P2 while still asserted moves the release to edge P2+TIMEOUT, with no intervening high.
- R8: A request that reappears during the post-release countdown reloads the full timeout. The output does not go high in between, and the release timing then follows R3.
- R9: During block reset `rst_out_n` is low. After reset is released it goes high on the TIMEOUT-th clock edge.
- R10: `reset_active` is always the inverse of `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| uv_main_i | input | 1 | Main supply below threshold (asynchronous, 1 = low) |
| uv_aux_i | input | 1 | Auxiliary monitored input below threshold (asynchronous, 1 = low) |
| mr_n_i | input | 1 | Raw manual-reset line, active low, asynchronous |
| wdog_fault_i | input | 1 | One-cycle watchdog fault strobe, synchronous to clk |
| rst_out_n | output | 1 | Processor reset, active low |
| reset_active | output | 1 | High while reset is asserted |

## Verification
The bench sweeps manual-reset pulse widths across the qualifying length, and a lone single-cycle high glitch between two sub-length lows. A qualifier that is off by one, or that fails to restart its count, would either let noise through or reject a valid press. It also sweeps the offset at which a request reappears during the countdown, up to the very cycle in which release would occur. A design that does not reload there would emit a short high glitch, or release early. Watchdog strobes, single and chained, pin down the exact pulse length, where an extra load cycle would show up as TIMEOUT+1. Each supply flag is checked with several hold lengths and with overlapping holds, which exposes a mix-up between the two flags or a miscount of the synchronizer depth.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  // bits needed to hold values 0..maxval (at least one bit)
  function automatic int width_for(int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/rs_mr_filter.sv
module rs_mr_filter #(
  parameter int MR_QUAL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_low_i,
  output logic act_o
);
  localparam int QW = rst_seq_pkg::width_for(MR_QUAL);
  localparam logic [QW-1:0] QMAX = QW'(MR_QUAL);

  logic [QW-1:0] low_cnt_q;
  logic [QW-1:0] low_cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = mr_low_i || (low_cnt_q != '0);
    if (!mr_low_i)
      low_cnt_d = '0;
    else if (low_cnt_q == QMAX)
      low_cnt_d = low_cnt_q;
    else
      low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt_q <= '0;
    else if (cnt_en)
      low_cnt_q <= low_cnt_d;
  end

  assign act_o = (low_cnt_q == QMAX);

  // R5: qualified press implies the line was low on the previous sample
  assert_act_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> $past(mr_low_i));
  // R5: a high sample drops the request on the next cycle
  assert_high_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_low_i |=> !act_o);
  // R4: width count never passes the qualifying length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt_q <= QMAX);
endmodule

// File: rtl/rs_stretch.sv
module rs_stretch #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic asserted_o
);
  localparam int CW = rst_seq_pkg::width_for(TIMEOUT - 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          asrt_q;
  logic          asrt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = cond_i || (cnt_q != '0);
    if (cond_i) begin
      cnt_d  = RELOAD;
      asrt_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      asrt_d = 1'b1;
    end else begin
      cnt_d  = cnt_q;
      asrt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      asrt_q <= 1'b1;
    end else begin
      if (cnt_en)
        cnt_q <= cnt_d;
      asrt_q <= asrt_d;
    end
  end

  assign asserted_o = asrt_q;

  // R1: any request forces assertion on the following cycle
  assert_cond_asserts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i |=> asrt_q);
  // R3: countdown in progress keeps reset asserted
  assert_hold_during_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond_i && cnt_q != '0) |=> asrt_q);
  // R8: release only after an empty counter with no request
  assert_release_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asrt_q) |-> ($past(cnt_q) == '0 && !$past(cond_i)));
  // R3: counter never exceeds its reload value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
endmodule

// File: rtl/supervisor_rst_seq.sv
module supervisor_rst_seq #(
  parameter int TIMEOUT = 1000,
  parameter int MR_QUAL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_main_i,
  input  logic uv_aux_i,
  input  logic mr_n_i,
  input  logic wdog_fault_i,
  output logic rst_out_n,
  output logic reset_active
);
  logic [2:0] raw_bus;
  logic [2:0] sync_bus;
  logic       uv_main_s;
  logic       uv_aux_s;
  logic       mr_low_s;
  logic       mr_act;
  logic       any_req;
  logic       asserted;

  assign raw_bus = {mr_n_i, uv_aux_i, uv_main_i};

  rs_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_bus),
    .sync_o  (sync_bus)
  );

  assign uv_main_s = sync_bus[0];
  assign uv_aux_s  = sync_bus[1];
  assign mr_low_s  = !sync_bus[2];

  rs_mr_filter #(.MR_QUAL(MR_QUAL)) u_mr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_low_i (mr_low_s),
    .act_o    (mr_act)
  );

  assign any_req = uv_main_s || uv_aux_s || mr_act || wdog_fault_i;

  rs_stretch #(.TIMEOUT(TIMEOUT)) u_str (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (any_req),
    .asserted_o (asserted)
  );

  assign rst_out_n    = !asserted;
  assign reset_active = asserted;

  // R1: synchronized main-supply flag reaches the output one cycle later
  assert_main_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_main_s |=> !rst_out_n);
  // R2: synchronized auxiliary flag reaches the output one cycle later
  assert_aux_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_aux_s |=> !rst_out_n);
  // R7: watchdog strobe asserts reset on the next cycle
  assert_wdog_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_fault_i |=> !rst_out_n);
endmodule

// File: tb/tb_supervisor_rst_seq.sv
module tb_supervisor_rst_seq;
  localparam int T = 6;
  localparam int Q = 3;

  logic clk;
  logic rst_n;
  logic uv_main, uv_aux, mr_n, wdog;
  logic rst_out_n, reset_active;

  int cyc, fall_at, rise_at, nfall, ra_bad;
  int errors, checks;
  logic prev;
  bit done;

  supervisor_rst_seq #(.TIMEOUT(T), .MR_QUAL(Q)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .uv_main_i    (uv_main),
    .uv_aux_i     (uv_aux),
    .mr_n_i       (mr_n),
    .wdog_fault_i (wdog),
    .rst_out_n    (rst_out_n),
    .reset_active (reset_active)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    prev = 1'b0;
    fall_at = -1;
    rise_at = -1;
    nfall = 0;
    ra_bad = 0;
  end

  always @(negedge clk) begin
    if (reset_active !== !rst_out_n) ra_bad = ra_bad + 1;
    if (rst_out_n !== prev) begin
      if (!rst_out_n) begin
        fall_at = cyc;
        nfall = nfall + 1;
      end else begin
        rise_at = cyc;
      end
      prev = rst_out_n;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    fall_at = -1;
    rise_at = -1;
    nfall = 0;
  endtask

  task automatic settle();
    repeat (T + 8) @(negedge clk);
  endtask

  task automatic supply_pulse(bit aux, int h, string tag);
    int p;
    int q;
    @(negedge clk);
    clear_log();
    p = cyc + 1;
    if (aux) uv_aux = 1'b1; else uv_main = 1'b1;
    repeat (h) @(negedge clk);
    uv_main = 1'b0;
    uv_aux = 1'b0;
    q = p + h;
    settle();
    chk(fall_at == p + 2, tag, fall_at, p + 2);
    chk(rise_at == q + 1 + T, "R3", rise_at, q + 1 + T);
  endtask

  task automatic mr_pulse(int w);
    int p;
    int r;
    @(negedge clk);
    clear_log();
    p = cyc + 1;
    mr_n = 1'b0;
    repeat (w) @(negedge clk);
    mr_n = 1'b1;
    r = p + w;
    settle();
    if (w >= Q) begin
      chk(fall_at == p + Q + 2, "R5", fall_at, p + Q + 2);
      chk(rise_at == r + 2 + T, "R6", rise_at, r + 2 + T);
    end else begin
      chk(nfall == 0, "R4", nfall, 0);
      chk(rst_out_n == 1'b1, "R4", rst_out_n, 1);
    end
  endtask

  initial begin
    int rel;
    int p;
    int p2;
    int q;
    int q2;
    errors = 0;
    checks = 0;
    done = 1'b0;
    rst_n = 1'b0;
    uv_main = 1'b0;
    uv_aux = 1'b0;
    mr_n = 1'b1;
    wdog = 1'b0;

    // R9 power-on pulse
    repeat (3) @(negedge clk);
    chk(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    rst_n = 1'b1;
    rel = cyc;
    settle();
    chk(rise_at == rel + T, "R9", rise_at, rel + T);
    chk(rst_out_n == 1'b1, "R9", rst_out_n, 1);

    // R1 / R2 supply flags, several hold lengths
    for (int h = 1; h <= 4; h++) supply_pulse(1'b0, h, "R1");
    for (int h = 1; h <= 4; h++) supply_pulse(1'b1, h, "R2");

    // R2 overlapping flags: release follows the later one
    @(negedge clk);
    clear_log();
    p = cyc + 1;
    uv_main = 1'b1;
    repeat (2) @(negedge clk);
    uv_aux = 1'b1;
    @(negedge clk);
    uv_main = 1'b0;
    repeat (3) @(negedge clk);
    uv_aux = 1'b0;
    q = p + 6;
    settle();
    chk(fall_at == p + 2, "R2", fall_at, p + 2);
    chk(rise_at == q + 1 + T, "R2", rise_at, q + 1 + T);
    chk(nfall == 1, "R2", nfall, 1);

    // R4 / R5 / R6 manual-reset width sweep
    for (int w = 1; w <= Q + 3; w++) mr_pulse(w);

    // R5 a one-cycle high glitch restarts the width count
    @(negedge clk);
    clear_log();
    mr_n = 1'b0;
    repeat (Q - 1) @(negedge clk);
    mr_n = 1'b1;
    @(negedge clk);
    mr_n = 1'b0;
    repeat (Q - 1) @(negedge clk);
    mr_n = 1'b1;
    settle();
    chk(nfall == 0, "R5", nfall, 0);

    // R7 single watchdog strobe
    @(negedge clk);
    clear_log();
    p = cyc + 1;
    wdog = 1'b1;
    @(negedge clk);
    wdog = 1'b0;
    settle();
    chk(fall_at == p, "R7", fall_at, p);
    chk(rise_at - fall_at == T, "R7", rise_at - fall_at, T);

    // R7 chained strobes extend the pulse
    for (int k = 1; k < T; k++) begin
      @(negedge clk);
      clear_log();
      p = cyc + 1;
      wdog = 1'b1;
      @(negedge clk);
      wdog = 1'b0;
      repeat (k - 1) @(negedge clk);
      wdog = 1'b1;
      p2 = p + k;
      @(negedge clk);
      wdog = 1'b0;
      settle();
      chk(rise_at == p2 + T, "R7", rise_at, p2 + T);
      chk(nfall == 1, "R7", nfall, 1);
    end

    // R8 request reappears during the countdown
    for (int k = 1; k < T; k++) begin
      @(negedge clk);
      clear_log();
      p = cyc + 1;
      uv_main = 1'b1;
      repeat (2) @(negedge clk);
      uv_main = 1'b0;
      q = p + 2;
      repeat (k) @(negedge clk);
      uv_main = 1'b1;
      @(negedge clk);
      uv_main = 1'b0;
      q2 = q + k + 1;
      settle();
      chk(nfall == 1, "R8", nfall, 1);
      chk(rise_at == q2 + 1 + T, "R8", rise_at, q2 + 1 + T);
    end

    chk(ra_bad == 0, "R10", ra_bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule